// File: doc/BRIEF.md
# Voltage/Frequency Operating Point Sequencer

This block moves one power domain between a small, ordered set of operating points. Each point pairs a supply voltage with a clock frequency. A policy source, such as a software register or a workload or thermal hint, asks for a level index. The block then issues one handshake to the supply regulator and one to the clock source. It orders the two so that the domain's logic is never clocked faster than the voltage already on the rail allows.

When it steps down, the block first switches the clock and waits until the clock source reports lock, and only then lowers the voltage. When it steps up, it first raises the voltage and waits until the regulator reports a settled rail, and only then raises the clock. A jump that spans several levels is made as a single pair of handshakes.

Requests that arrive mid-transition are held in one slot, and the newest one replaces any older one. Any request that would put the rail under a configured voltage floor is raised to the lowest level that meets the floor. Every wait has a timeout. When a wait expires, the block drops back to the last operating point it completed and sets a sticky error flag.

Top module: `opp_step_sequencer`

## Requirements
- R1: There are three levels: index 0 is Low, 1 is Nominal and 2 is Turbo. The voltage code counts 10 mV units and takes the values 80, 90 and 100. The clock-select code counts 100 MHz units and takes the values 6, 9 and 12. After reset, `cur_level` is 1, `vreg_code` is 90 and `clk_sel` is 9, with `busy`, `err`, `vreg_req` and `clk_req` all low.
- R2: When the target level is below the current level, `clk_req` rises first, carrying the new clock code. `vreg_req` rises only after `clk_ack` has been seen. The two requests are never high at the same time.
- R3: When the target level is above the current level, `vreg_req` rises first, carrying the new voltage code, and the clock code keeps its old value. `clk_req` rises only after `vreg_ack` has been seen.
- R4: A request stays high, with its code unchanged, until its acknowledge arrives or its wait times out. A step is never treated as finished in the cycle it is issued.
- R5: When `vmin_code` is above the voltage code of the requested level, the target becomes the lowest level whose voltage code is at least `vmin_code`. No voltage below the floor is ever requested.
- R6: At every cycle, the level that `clk_sel` encodes is no higher than the level that `vreg_code` encodes.
- R7: A request that arrives while `busy` is high is stored and started once the current transition ends. A later request overwrites an earlier one.
- R8: If a request, after clamping, equals `cur_level`, it starts no handshake and leaves `busy` low.
- R9: `busy` rises on the clock edge where a request is accepted and falls on the edge where the last acknowledge is taken. `cur_level` changes only on that falling edge.
- R10: If an acknowledge has not arrived within `tmo_limit` cycles of a wait, both codes return to those of `cur_level` and both requests drop. `busy` clears and `err` is set. Only reset clears `err`.
- R11: A level index above 2 is treated as Turbo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe carrying a new level request |
| req_level | input | 2 | Requested level index |
| vmin_code | input | 7 | Minimum safe voltage code (10 mV units) |
| tmo_limit | input | 8 | Timeout for each handshake wait, in cycles |
| vreg_code | output | 7 | Voltage code commanded to the regulator |
| vreg_req | output | 1 | Regulator change request, held until acknowledged |
| vreg_ack | input | 1 | Regulator reports the rail has settled |
| clk_sel | output | 5 | Clock-select code commanded to the clock source |
| clk_req | output | 1 | Clock change request, held until acknowledged |
| clk_ack | input | 1 | Clock source reports it is locked |
| busy | output | 1 | A transition is in progress |
| cur_level | output | 2 | Last fully completed level |
| err | output | 1 | Sticky timeout flag |

## Verification
The assertions take for granted that `vmin_code` and `tmo_limit` stay constant while `busy` is high. They also take for granted that each responder pulses its acknowledge for exactly one cycle, and only while its own request is high. The floor check relies on that constant floor. In the bench, the regulator and clock models raise an acknowledge only after they have seen their request high for a programmed number of cycles, then lower it. The floor and the timeout are changed only between transitions, while the block is idle.

// File: rtl/opp_seq_pkg.sv
package opp_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_VWAIT = 2'd1,
    ST_CWAIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/opp_code_table.sv
module opp_code_table #(
  parameter int NUM_LVL = 3,
  parameter int LW      = 2,
  parameter int VW      = 7,
  parameter int CW      = 5,
  parameter int V_LO    = 80,
  parameter int V_STEP  = 10,
  parameter int F_LO    = 6,
  parameter int F_STEP  = 3
) (
  input  logic [VW-1:0]               vmin_code,
  input  logic [LW-1:0]               req_level,
  output logic [NUM_LVL-1:0][VW-1:0]  vtab,
  output logic [NUM_LVL-1:0][CW-1:0]  ctab,
  output logic [LW-1:0]               req_clamped
);

  localparam logic [LW-1:0] TOP_LVL = LW'(NUM_LVL - 1);

  // Codes grow linearly with the level index.
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_point
    assign vtab[g] = VW'(V_LO + g * V_STEP);
    assign ctab[g] = CW'(F_LO + g * F_STEP);
  end

  logic [LW-1:0] floor_lvl;
  logic          floor_hit;
  logic [LW-1:0] in_range;

  // The floor is the lowest level whose voltage is at or above the minimum.
  always_comb begin
    floor_lvl = TOP_LVL;
    floor_hit = 1'b0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (!floor_hit && (vtab[i] >= vmin_code)) begin
        floor_lvl = LW'(i);
        floor_hit = 1'b1;
      end
    end
  end

  always_comb begin
    in_range    = (req_level > TOP_LVL) ? TOP_LVL : req_level;
    req_clamped = (in_range < floor_lvl) ? floor_lvl : in_range;
  end

endmodule

// File: rtl/opp_req_hold.sv
module opp_req_hold #(
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [LW-1:0] cap_lvl,
  input  logic          take,
  output logic          pend_valid,
  output logic [LW-1:0] pend_lvl
);

  // Single slot: a newer capture overwrites, capture beats consumption.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_lvl   <= '0;
    end else if (cap) begin
      pend_valid <= 1'b1;
      pend_lvl   <= cap_lvl;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/opp_wait_timer.sv
module opp_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          rearm,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  // Counts cycles spent in the current wait; saturates at the limit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!arm || rearm) begin
      cnt_q <= '0;
    end else if (cnt_q != limit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = arm && !rearm && (cnt_q == limit);

endmodule

// File: rtl/opp_step_sequencer.sv
module opp_step_sequencer
  import opp_seq_pkg::*;
#(
  parameter int NUM_LVL = 3,
  parameter int VW      = 7,
  parameter int CW      = 5,
  parameter int TW      = 8,
  parameter int V_LO    = 80,
  parameter int V_STEP  = 10,
  parameter int F_LO    = 6,
  parameter int F_STEP  = 3,
  parameter int RST_LVL = 1,
  localparam int LW     = $clog2(NUM_LVL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [LW-1:0] req_level,
  input  logic [VW-1:0] vmin_code,
  input  logic [TW-1:0] tmo_limit,
  output logic [VW-1:0] vreg_code,
  output logic          vreg_req,
  input  logic          vreg_ack,
  output logic [CW-1:0] clk_sel,
  output logic          clk_req,
  input  logic          clk_ack,
  output logic          busy,
  output logic [LW-1:0] cur_level,
  output logic          err
);

  localparam logic [LW-1:0] RST_IDX = LW'(RST_LVL);

  logic [NUM_LVL-1:0][VW-1:0] vtab;
  logic [NUM_LVL-1:0][CW-1:0] ctab;
  logic [LW-1:0]              req_clamp;
  logic                       pend_valid;
  logic [LW-1:0]              pend_lvl;
  logic                       tmo_hit;

  seq_state_e    st_q;
  logic          step_up_q;
  logic [LW-1:0] tgt_q;
  logic [LW-1:0] done_q;
  logic [VW-1:0] vcode_q;
  logic [CW-1:0] csel_q;
  logic          vreq_q;
  logic          creq_q;
  logic          busy_q;
  logic          err_q;

  logic          idle;
  logic          have_req;
  logic [LW-1:0] cand;
  logic          v_done;
  logic          c_done;

  opp_code_table #(
    .NUM_LVL(NUM_LVL), .LW(LW), .VW(VW), .CW(CW),
    .V_LO(V_LO), .V_STEP(V_STEP), .F_LO(F_LO), .F_STEP(F_STEP)
  ) u_table (
    .vmin_code  (vmin_code),
    .req_level  (req_level),
    .vtab       (vtab),
    .ctab       (ctab),
    .req_clamped(req_clamp)
  );

  assign idle     = (st_q == ST_IDLE);
  assign have_req = req_valid || pend_valid;
  assign cand     = req_valid ? req_clamp : pend_lvl;
  assign v_done   = (st_q == ST_VWAIT) && vreg_ack;
  assign c_done   = (st_q == ST_CWAIT) && clk_ack;

  opp_req_hold #(.LW(LW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (req_valid && !idle),
    .cap_lvl   (req_clamp),
    .take      (idle && have_req),
    .pend_valid(pend_valid),
    .pend_lvl  (pend_lvl)
  );

  opp_wait_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (!idle),
    .rearm  (v_done || c_done),
    .limit  (tmo_limit),
    .expired(tmo_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      step_up_q <= 1'b0;
      tgt_q     <= RST_IDX;
      done_q    <= RST_IDX;
      vcode_q   <= vtab[RST_IDX];
      csel_q    <= ctab[RST_IDX];
      vreq_q    <= 1'b0;
      creq_q    <= 1'b0;
      busy_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (have_req && (cand != done_q)) begin
            busy_q <= 1'b1;
            tgt_q  <= cand;
            if (cand > done_q) begin
              // Upward: rail first.
              step_up_q <= 1'b1;
              vcode_q   <= vtab[cand];
              vreq_q    <= 1'b1;
              st_q      <= ST_VWAIT;
            end else begin
              // Downward: clock first.
              step_up_q <= 1'b0;
              csel_q    <= ctab[cand];
              creq_q    <= 1'b1;
              st_q      <= ST_CWAIT;
            end
          end
        end
        ST_VWAIT: begin
          if (vreg_ack) begin
            vreq_q <= 1'b0;
            if (step_up_q) begin
              csel_q <= ctab[tgt_q];
              creq_q <= 1'b1;
              st_q   <= ST_CWAIT;
            end else begin
              done_q <= tgt_q;
              busy_q <= 1'b0;
              st_q   <= ST_IDLE;
            end
          end else if (tmo_hit) begin
            vcode_q <= vtab[done_q];
            csel_q  <= ctab[done_q];
            vreq_q  <= 1'b0;
            creq_q  <= 1'b0;
            busy_q  <= 1'b0;
            err_q   <= 1'b1;
            st_q    <= ST_IDLE;
          end
        end
        ST_CWAIT: begin
          if (clk_ack) begin
            creq_q <= 1'b0;
            if (!step_up_q) begin
              vcode_q <= vtab[tgt_q];
              vreq_q  <= 1'b1;
              st_q    <= ST_VWAIT;
            end else begin
              done_q <= tgt_q;
              busy_q <= 1'b0;
              st_q   <= ST_IDLE;
            end
          end else if (tmo_hit) begin
            vcode_q <= vtab[done_q];
            csel_q  <= ctab[done_q];
            vreq_q  <= 1'b0;
            creq_q  <= 1'b0;
            busy_q  <= 1'b0;
            err_q   <= 1'b1;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign vreg_code = vcode_q;
  assign vreg_req  = vreq_q;
  assign clk_sel   = csel_q;
  assign clk_req   = creq_q;
  assign busy      = busy_q;
  assign cur_level = done_q;
  assign err       = err_q;

endmodule

// File: rtl/opp_step_sva.sv
module opp_step_sva #(
  parameter int NUM_LVL = 3,
  parameter int VW      = 7,
  parameter int CW      = 5,
  parameter int V_LO    = 80,
  parameter int V_STEP  = 10,
  parameter int F_LO    = 6,
  parameter int F_STEP  = 3,
  localparam int LW     = $clog2(NUM_LVL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [VW-1:0] vmin_code,
  input logic [VW-1:0] vreg_code,
  input logic          vreg_req,
  input logic          vreg_ack,
  input logic [CW-1:0] clk_sel,
  input logic          clk_req,
  input logic          clk_ack,
  input logic          busy,
  input logic [LW-1:0] cur_level,
  input logic          err
);

  localparam int VTOP = V_LO + (NUM_LVL - 1) * V_STEP;

  int v_lvl;
  int c_lvl;
  always_comb begin
    v_lvl = (int'(vreg_code) - V_LO) / V_STEP;
    c_lvl = (int'(clk_sel) - F_LO) / F_STEP;
  end

  AST_PAIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    c_lvl <= v_lvl); // R6
  AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(vreg_req && clk_req)); // R2
  AST_VREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_req && !vreg_ack) |=> (vreg_req || !busy)); // R4
  AST_VCODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_req |=> (!vreg_req || $stable(vreg_code))); // R4
  AST_CREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_req && !clk_ack) |=> (clk_req || !busy)); // R4
  AST_FLOOR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_req && (int'(vmin_code) <= VTOP)) |-> (vreg_code >= vmin_code)); // R5
  AST_LVL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_level) |-> $fell(busy)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!vreg_req && !clk_req)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R10
  AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_level) <= NUM_LVL - 1); // R1

endmodule

bind opp_step_sequencer opp_step_sva #(
  .NUM_LVL(NUM_LVL), .VW(VW), .CW(CW),
  .V_LO(V_LO), .V_STEP(V_STEP), .F_LO(F_LO), .F_STEP(F_STEP)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .vmin_code(vmin_code),
  .vreg_code(vreg_code),
  .vreg_req (vreg_req),
  .vreg_ack (vreg_ack),
  .clk_sel  (clk_sel),
  .clk_req  (clk_req),
  .clk_ack  (clk_ack),
  .busy     (busy),
  .cur_level(cur_level),
  .err      (err)
);

// File: tb/test_opp_step_sequencer.sv
`timescale 1ns/1ps
module test_opp_step_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_level = 2'd0;
  logic [6:0] vmin_code = 7'd80;
  logic [7:0] tmo_limit = 8'd40;
  logic [6:0] vreg_code;
  logic       vreg_req;
  logic       vreg_ack = 1'b0;
  logic [4:0] clk_sel;
  logic       clk_req;
  logic       clk_ack = 1'b0;
  logic       busy;
  logic [1:0] cur_level;
  logic       err;

  int total = 0;
  int bad = 0;
  int v_dly = 3;
  int c_dly = 3;
  bit v_en = 1'b1;
  int ev[16];
  int nev = 0;
  int pair_bad = 0;

  always #2 clk = ~clk;

  opp_step_sequencer i_opp_step_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .vmin_code(vmin_code), .tmo_limit(tmo_limit),
    .vreg_code(vreg_code), .vreg_req(vreg_req), .vreg_ack(vreg_ack),
    .clk_sel(clk_sel), .clk_req(clk_req), .clk_ack(clk_ack),
    .busy(busy), .cur_level(cur_level), .err(err)
  );

  // Regulator model.
  initial forever begin
    @(negedge clk);
    if (vreg_req && v_en) begin
      repeat (v_dly) @(negedge clk);
      vreg_ack = 1'b1;
      @(negedge clk);
      vreg_ack = 1'b0;
    end
  end

  // Clock source model.
  initial forever begin
    @(negedge clk);
    if (clk_req) begin
      repeat (c_dly) @(negedge clk);
      clk_ack = 1'b1;
      @(negedge clk);
      clk_ack = 1'b0;
    end
  end

  // Event log of request rises, plus continuous pair-order watch (R6).
  initial begin
    bit pv = 1'b0;
    bit pc = 1'b0;
    forever begin
      @(negedge clk);
      if (vreg_req && !pv && nev < 16) begin ev[nev] = 1000 + int'(vreg_code); nev++; end
      if (clk_req && !pc && nev < 16) begin ev[nev] = 2000 + int'(clk_sel); nev++; end
      pv = vreg_req;
      pc = clk_req;
      if (rst_n && ((int'(clk_sel) - 6) / 3 > (int'(vreg_code) - 80) / 10)) pair_bad++;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(int lvl);
    @(negedge clk);
    req_valid = 1'b1;
    req_level = 2'(lvl);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(int lvl);
    for (int i = 0; i < 400; i++) begin
      if (!busy && int'(cur_level) == lvl) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset level", int'(cur_level), 1);
    chk("R1", "reset vcode", int'(vreg_code), 90);
    chk("R1", "reset csel", int'(clk_sel), 9);
    chk("R1", "reset flags busy/err/reqs", {busy, err, vreg_req, clk_req}, 0);
  endtask

  task automatic t_step_down();
    nev = 0;
    issue(0);
    chk("R9", "busy on accept", int'(busy), 1);
    chk("R9", "level held while busy", int'(cur_level), 1);
    chk("R2", "clock request first", int'(clk_req), 1);
    wait_done(0);
    chk("R2", "event count", nev, 2);
    chk("R2", "first event clock 6", ev[0], 2006);
    chk("R2", "second event volt 80", ev[1], 1080);
    chk("R1", "low codes", {int'(vreg_code), int'(clk_sel)}, {32'd80, 32'd6});
  endtask

  task automatic t_step_up();
    v_dly = 6;
    nev = 0;
    issue(2);
    chk("R3", "volt request first", int'(vreg_req), 1);
    chk("R3", "clock unchanged at start", int'(clk_sel), 6);
    repeat (3) @(negedge clk);
    chk("R4", "still waiting on rail", {busy, vreg_req, clk_req}, 3'b110);
    wait_done(2);
    chk("R3", "event count", nev, 2);
    chk("R3", "first event volt 100", ev[0], 1100);
    chk("R3", "second event clock 12", ev[1], 2012);
    chk("R1", "turbo codes", {int'(vreg_code), int'(clk_sel)}, {32'd100, 32'd12});
    v_dly = 3;
  endtask

  task automatic t_same_level();
    nev = 0;
    issue(2);
    chk("R8", "busy stays low", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk("R8", "no handshake", nev, 0);
    chk("R8", "level kept", int'(cur_level), 2);
  endtask

  task automatic t_latest_wins();
    c_dly = 4;
    nev = 0;
    issue(0);
    req_valid = 1'b1; req_level = 2'd2;
    @(negedge clk);
    req_level = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(1);
    chk("R7", "final level newest", int'(cur_level), 1);
    chk("R7", "event count", nev, 4);
    chk("R7", "third event volt 90", ev[2], 1090);
    chk("R7", "fourth event clock 9", ev[3], 2009);
    c_dly = 3;
  endtask

  task automatic t_floor();
    vmin_code = 7'd85;
    nev = 0;
    issue(0);
    chk("R5", "clamped to current ignored", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk("R5", "no handshake under floor", nev, 0);
    vmin_code = 7'd95;
    issue(0);
    wait_done(2);
    chk("R5", "clamped up to turbo", int'(cur_level), 2);
    chk("R5", "rail above floor", int'(vreg_code), 100);
    vmin_code = 7'd80;
  endtask

  task automatic t_out_of_range();
    issue(0);
    wait_done(0);
    nev = 0;
    issue(3);
    wait_done(2);
    chk("R11", "index 3 reaches turbo", int'(cur_level), 2);
    chk("R11", "first event volt 100", ev[0], 1100);
  endtask

  task automatic t_timeout();
    tmo_limit = 8'd10;
    v_en = 1'b0;
    nev = 0;
    issue(0);
    wait_done(2);
    chk("R10", "err set", int'(err), 1);
    chk("R10", "codes back to turbo", {int'(vreg_code), int'(clk_sel)}, {32'd100, 32'd12});
    chk("R10", "requests dropped", {busy, vreg_req, clk_req}, 0);
    chk("R10", "clock step was made", ev[0], 2006);
    v_en = 1'b1;
    tmo_limit = 8'd40;
    issue(1);
    wait_done(1);
    chk("R10", "err sticky", int'(err), 1);
    chk("R10", "later move works", int'(clk_sel), 9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_step_down();
    t_step_up();
    t_same_level();
    t_latest_wins();
    t_floor();
    t_out_of_range();
    t_timeout();
    chk("R6", "clock never above rail", pair_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule